// File: doc/BRIEF.md
# Integer Execute Unit with Flag Register and Branch Resolver

This block is the arithmetic stage of a small 32-bit integer datapath. A 4-bit operation selector picks one of four two-operand functions on the operand words `opnd_a` and `opnd_b`, and the result appears combinationally on `result`. From the same result the block works out zero, negative and signed-overflow indications. A three-bit flag register captures them on a rising clock edge, but only when the capture strobe is high.

A separate combinational resolver reads the stored flags and a 4-bit condition selector, and says whether a conditional transfer of control should be taken. The flag register is written as a tiny state machine. Its state is the flag triple, and the only transitions are "hold" and "capture". The pipeline that surrounds the block issues an operation with the strobe high. A later control-transfer instruction then presents its condition selector and reads `take`.

The flag register has two named transitions. HOLD applies when `flag_we` is low and leaves the flags unchanged. CAPTURE applies when `flag_we` is high and loads the freshly computed flags. Reset drives the register to the state ZERO_SET, in which the zero flag is 1 and the other two flags are 0.

Top module: `exec_unit`

## Requirements
- R1: Operation selector 0 gives `result` = B + A and selector 1 gives `result` = B − A, both modulo 2^32. B is `opnd_b` and A is `opnd_a`.
- R2: Operation selector 2 gives `result` = B AND A and selector 3 gives `result` = B XOR A. Selectors 4 to 15 give `result` = 0 and a flag update from that zero value.
- R3: For add, the computed overflow is 1 exactly when A and B have the same sign and the result's sign differs from it. For subtract, it is 1 exactly when A and B differ in sign and the result's sign differs from B's. For AND, XOR and selectors 4 to 15, it is 0.
- R4: The computed zero flag is 1 exactly when `result` is 0. The computed negative flag equals bit 31 of `result`.
- R5: On a rising edge with `flag_we` high, `flag_zf`, `flag_sf` and `flag_of` take the values computed from that cycle's operands. This holds for all four operations.
- R6: On a rising edge with `flag_we` low, the stored flags keep their values whatever the operands and selector are.
- R7: While `rst_n` is low, the stored flags are ZF=1, SF=0 and OF=0.
- R8: `take` is decided from the stored flags by `cond_sel`. The codes are: 0 always; 1 when (SF^OF)|ZF; 2 when SF^OF; 3 when ZF; 4 when !ZF; 5 when !(SF^OF); 6 when !(SF^OF)&!ZF.
- R9: `cond_sel` values 7 to 15 give `take` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| op_sel | input | 4 | Operation selector |
| flag_we | input | 1 | Flag capture strobe |
| cond_sel | input | 4 | Condition selector for the branch resolver |
| result | output | 32 | Operation result (combinational) |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored negative flag |
| flag_of | output | 1 | Stored signed-overflow flag |
| take | output | 1 | Branch-taken decision from the stored flags |

## Verification
A wrong internal state here is a wrong flag triple. Any wrong flag becomes visible on the flag ports one edge after the capture that corrupted it. It also shows on `take` in the same cycle for every condition that depends on that flag. A capture that should have been a hold, or the other way round, shows only when the following operation produces different flags. For that reason the stimulus alternates capture and hold cycles with differing operands, and it probes all sixteen condition codes against each stored state.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        C_ALWAYS = 4'd0,
        C_LE     = 4'd1,
        C_LT     = 4'd2,
        C_EQ     = 4'd3,
        C_NE     = 4'd4,
        C_GE     = 4'd5,
        C_GT     = 4'd6
    } cond_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     y,
    output flags_t           nxt
);
    localparam int MSB = W - 1;

    logic [W-1:0] sum, diff;
    logic         ovf_add, ovf_sub;

    assign sum     = b + a;
    assign diff    = b - a;
    assign ovf_add = (a[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
    assign ovf_sub = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);

    always_comb begin
        y      = '0;
        nxt.of = 1'b0;
        unique case (sel)
            OP_ADD: begin y = sum;  nxt.of = ovf_add; end
            OP_SUB: begin y = diff; nxt.of = ovf_sub; end
            OP_AND: y = b & a;
            OP_XOR: y = b ^ a;
            default: y = '0;
        endcase
        nxt.zf = (y == '0);
        nxt.sf = y[MSB];
    end
endmodule

// File: rtl/exec_flags.sv
module exec_flags
    import exec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  flags_t nxt,
    output flags_t cur
);
    typedef enum logic {
        T_HOLD    = 1'b0,
        T_CAPTURE = 1'b1
    } trans_e;

    trans_e trans;
    flags_t state_d;

    assign trans = we ? T_CAPTURE : T_HOLD;

    always_comb begin
        state_d = cur;
        unique case (trans)
            T_HOLD:    state_d = cur;
            T_CAPTURE: state_d = nxt;
            default:   state_d = cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur <= FLAGS_RESET;
        else        cur <= state_d;
    end
endmodule

// File: rtl/exec_cond.sv
module exec_cond
    import exec_pkg::*;
(
    input  flags_t           f,
    input  logic [SEL_W-1:0] sel,
    output logic             take
);
    logic lt;
    assign lt = f.sf ^ f.of;

    always_comb begin
        take = 1'b0;
        unique case (sel)
            C_ALWAYS: take = 1'b1;
            C_LE:     take = lt | f.zf;
            C_LT:     take = lt;
            C_EQ:     take = f.zf;
            C_NE:     take = ~f.zf;
            C_GE:     take = ~lt;
            C_GT:     take = ~lt & ~f.zf;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exec_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [SEL_W-1:0] op_sel,
    input  logic             flag_we,
    input  logic [SEL_W-1:0] cond_sel,
    output logic [W-1:0]     result,
    output logic             flag_zf,
    output logic             flag_sf,
    output logic             flag_of,
    output logic             take
);
    flags_t nxt_flags, cur_flags;

    exec_alu #(.W(W)) u_alu (
        .a(opnd_a), .b(opnd_b), .sel(op_sel), .y(result), .nxt(nxt_flags)
    );

    exec_flags u_flags (
        .clk(clk), .rst_n(rst_n), .we(flag_we), .nxt(nxt_flags), .cur(cur_flags)
    );

    exec_cond u_cond (
        .f(cur_flags), .sel(cond_sel), .take(take)
    );

    assign flag_zf = cur_flags.zf;
    assign flag_sf = cur_flags.sf;
    assign flag_of = cur_flags.of;
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [3:0]  op_sel,
    input logic        flag_we,
    input logic [3:0]  cond_sel,
    input logic [31:0] result,
    input logic        flag_zf,
    input logic        flag_sf,
    input logic        flag_of,
    input logic        take
);
    a_r6_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && $past(rst_n)) |=> $stable({flag_zf, flag_sf, flag_of}));

    a_r5_zero_capture: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flag_zf == ($past(result) == 32'd0)));

    a_r5_sign_capture: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flag_sf == $past(result[31])));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel >= 4'd2) |=> !flag_of);

    a_r9_unused_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel >= 4'd7) |-> !take);

    a_r8_always: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0) |-> take);

    a_r8_eq_ne: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd3) |-> (take == flag_zf));
endmodule

bind exec_unit exec_unit_chk u_chk (.*);

// File: tb/sim_exec_unit.sv
`timescale 1ns/1ps
module sim_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [3:0]  op = '0, cs = '0;
    logic        we = 1'b0;
    logic [31:0] result;
    logic        zf, sf, of, take;

    int n_chk = 0, n_fail = 0;
    logic ezf = 1'b1, esf = 1'b0, eof = 1'b0;

    always #4 clk = ~clk;

    exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .op_sel(op),
        .flag_we(we), .cond_sel(cs), .result(result),
        .flag_zf(zf), .flag_sf(sf), .flag_of(of), .take(take)
    );

    function automatic logic [31:0] m_res(input logic [31:0] x, y, input logic [3:0] s);
        case (s)
            4'd0: return y + x;
            4'd1: return y - x;
            4'd2: return y & x;
            4'd3: return y ^ x;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_of(input logic [31:0] x, y, input logic [3:0] s);
        logic signed [32:0] w;
        if (s == 4'd0) begin
            w = $signed({y[31], y}) + $signed({x[31], x});
            return w[32] != w[31];
        end
        if (s == 4'd1) begin
            w = $signed({y[31], y}) - $signed({x[31], x});
            return w[32] != w[31];
        end
        return 1'b0;
    endfunction

    function automatic logic m_take(input logic z, s, o, input logic [3:0] c);
        case (c)
            4'd0: return 1'b1;
            4'd1: return (s ^ o) | z;
            4'd2: return s ^ o;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return !(s ^ o);
            4'd6: return !(s ^ o) && !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input string tag);
        chk(tag, {29'd0, zf, sf, of}, {29'd0, ezf, esf, eof});
    endtask

    task automatic check_conds();
        for (int c = 0; c < 16; c++) begin
            cs = c[3:0];
            #1;
            chk((c >= 7) ? "R9 take unused code" : "R8 take", {31'd0, take},
                {31'd0, m_take(ezf, esf, eof, c[3:0])});
        end
    endtask

    task automatic apply(input logic [31:0] x, y, input logic [3:0] s, input logic w);
        logic [31:0] r;
        a = x; b = y; op = s; we = w;
        #1;
        r = m_res(x, y, s);
        chk((s <= 4'd1) ? "R1 result" : "R2 result", result, r);
        @(posedge clk);
        #2;
        if (w) begin
            ezf = (r == 32'd0); esf = r[31]; eof = m_of(x, y, s);
            check_flags((s >= 4'd2) ? "R3 R4 R5 flags" : "R4 R5 flags");
        end else begin
            check_flags("R6 hold");
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
            end
            begin
                void'($urandom(32'd1234));
                repeat (3) @(posedge clk);
                #2;
                check_flags("R7 reset state");
                check_conds();
                rst_n = 1'b1;
                // R3 directed overflow corners
                apply(32'h0000_0001, 32'h7fff_ffff, 4'd0, 1'b1);
                check_conds();
                apply(32'h0000_0001, 32'h8000_0000, 4'd1, 1'b1);
                check_conds();
                apply(32'h8000_0000, 32'h8000_0000, 4'd0, 1'b1);
                apply(32'h1234_5678, 32'h1234_5678, 4'd1, 1'b1);
                check_conds();
                apply(32'hffff_ffff, 32'h0000_0000, 4'd1, 1'b1);
                apply(32'hffff_0000, 32'h0f0f_f0f0, 4'd2, 1'b1);
                apply(32'h8000_0000, 32'h7fff_ffff, 4'd3, 1'b1);
                apply(32'h5555_5555, 32'h0000_0001, 4'd9, 1'b1);
                check_conds();
                apply(32'h7fff_ffff, 32'hffff_ffff, 4'd0, 1'b0);
                apply(32'h0, 32'h0, 4'd2, 1'b0);
                // R7 reset in mid-run
                rst_n = 1'b0;
                @(posedge clk); #2;
                ezf = 1'b1; esf = 1'b0; eof = 1'b0;
                check_flags("R7 reset again");
                rst_n = 1'b1;
                for (int i = 0; i < 400; i++) begin
                    logic [31:0] x, y;
                    x = $urandom();
                    y = $urandom();
                    if ((i % 7) == 0) y = x;
                    if ((i % 11) == 0) x = {~y[31], x[30:0]};
                    apply(x, y, 4'($urandom_range(0, 4)), ($urandom() % 3) != 0);
                    if ((i % 25) == 0) check_conds();
                end
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule